// File: doc/BRIEF.md
# Masked Data and Program Counter Breakpoint Comparator

This block is the matching stage of a debug trigger unit. It watches a processor's 32-bit local data bus and its program counter. It flags a data transfer whose operand equals a programmed breakpoint value, and it flags a fetch address that equals a programmed instruction breakpoint. For each comparison a mask register names the bit positions to ignore. A set mask bit means the bit is a don't-care.

The data bus uses big-endian byte lanes. On every transfer the block takes the two low address bits and the access size and uses them to pull the operand from the correct lanes. The operand is then right-justified. Byte, word and longword references can therefore hit at any offset, whether aligned or misaligned. Narrow operands are compared only against the low 8 or 16 bits of the value and mask registers.

Both hit outputs are registered, single-cycle pulses. A simple write port loads the four registers. Software or a trigger sequencer sets the two enable bits that allow each comparison to take part.

Top module: `bpc_trigger`

## Requirements
- R1: While `rst` is high, `data_hit` and `pc_hit` are low on the following clock edge. Reset clears all four registers to zero.
- R2: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_sel`: 0 = data value, 1 = data mask, 2 = PC value, 3 = PC mask. The new value is used from the next cycle.
- R3: A longword transfer (`xfer_size` = 2'b00) compares all 32 data bits. A bit counts only when its data mask bit is 0. A set mask bit makes that position always match.
- R4: A byte transfer (`xfer_size` = 2'b01) selects lane [31:24], [23:16], [15:8] or [7:0] for `xfer_addr` 0, 1, 2 or 3. That lane is compared against bits [7:0] of the data value under bits [7:0] of the data mask.
- R5: A word transfer (`xfer_size` = 2'b10) selects [31:16] when `xfer_addr[1]` is 0 and [15:0] when it is 1. `xfer_addr[0]` has no effect. The lane is compared against bits [15:0] of the value and mask.
- R6: `xfer_size` = 2'b11 never produces a data hit.
- R7: `data_hit` is high for exactly the one cycle after a clock edge at which `xfer_valid` and `data_en` were both high and the operand matched. Otherwise it is low.
- R8: `pc_hit` is high for the one cycle after an edge at which `pc_valid` and `pc_en` were high and `pc_value` matched the PC value on every bit whose PC mask bit is 0.
- R9: When `pc_en` is low, no PC strobe produces `pc_hit`.
- R10: With the data mask all ones, every valid, enabled transfer of a legal size hits, whatever its data and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 data value, 1 data mask, 2 PC value, 3 PC mask |
| wr_data | input | 32 | Register write data |
| data_en | input | 1 | Allows the data comparison to trigger |
| pc_en | input | 1 | Allows the PC comparison to trigger |
| xfer_valid | input | 1 | Data transfer qualifier |
| xfer_addr | input | 2 | Low address bits of the transfer |
| xfer_size | input | 2 | 00 longword, 01 byte, 10 word, 11 reserved |
| xfer_data | input | 32 | Data bus contents |
| pc_valid | input | 1 | Program counter strobe |
| pc_value | input | 32 | Program counter |
| data_hit | output | 1 | Registered data breakpoint pulse |
| pc_hit | output | 1 | Registered PC breakpoint pulse |

## Verification
The assertions assume that the register contents seen by a comparison are the ones held before any write in the same cycle. A write and a compare in one cycle therefore see the old value. The bench never issues a write in the same cycle as a transfer or PC strobe whose result it checks. Each write is followed by at least one idle cycle before a probe. The assertions also assume that reset is applied at the first edge. The bench holds `rst` high for several cycles before it drives anything else. While reset is high, all strobes are kept low.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int DW      = 32;
    localparam int BYTE_W  = 8;
    localparam int HALF_W  = DW / 2;
    localparam int N_LANES = DW / BYTE_W;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        RS_DVAL  = 2'd0,
        RS_DMASK = 2'd1,
        RS_PVAL  = 2'd2,
        RS_PMASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0] opnd;     // right-justified operand
        logic [DW-1:0] width_m;  // ones where operand bits are meaningful
        logic          legal;    // size code is usable
    } lane_sel_t;

    function automatic logic [DW-1:0] width_mask_of(acc_size_e s);
        case (s)
            SZ_BYTE: width_mask_of = {{(DW-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            SZ_WORD: width_mask_of = {{(DW-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            SZ_LONG: width_mask_of = {DW{1'b1}};
            default: width_mask_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/bpc_regfile.sv
module bpc_regfile
    import bpc_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] dval,
    output logic [DW-1:0] dmask,
    output logic [PW-1:0] pval,
    output logic [PW-1:0] pmask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dval  <= '0;
            dmask <= '0;
            pval  <= '0;
            pmask <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                RS_DVAL:  dval  <= wr_data;
                RS_DMASK: dmask <= wr_data;
                RS_PVAL:  pval  <= PW'(wr_data);
                RS_PMASK: pmask <= PW'(wr_data);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bpc_lane_align.sv
module bpc_lane_align
    import bpc_pkg::*;
(
    input  logic [1:0]    addr,
    input  logic [1:0]    size,
    input  logic [DW-1:0] data,
    output lane_sel_t     sel
);

    acc_size_e           sz;
    logic [BYTE_W-1:0]   byte_lane;
    logic [HALF_W-1:0]   half_lane;

    assign sz = acc_size_e'(size);

    // big-endian lanes: address 0 is the most significant byte
    assign byte_lane = data[BYTE_W*(N_LANES-1-int'(addr)) +: BYTE_W];
    assign half_lane = addr[1] ? data[HALF_W-1:0] : data[DW-1:HALF_W];

    always_comb begin
        sel.width_m = width_mask_of(sz);
        sel.legal   = (sz != SZ_RSVD);
        case (sz)
            SZ_BYTE: sel.opnd = {{(DW-BYTE_W){1'b0}}, byte_lane};
            SZ_WORD: sel.opnd = {{(DW-HALF_W){1'b0}}, half_lane};
            SZ_LONG: sel.opnd = data;
            default: sel.opnd = '0;
        endcase
    end

endmodule

// File: rtl/bpc_masked_eq.sv
module bpc_masked_eq #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] ignore,
    output logic         eq
);

    assign eq = (((a ^ b) & ~ignore) == '0);

endmodule

// File: rtl/bpc_trigger.sv
module bpc_trigger
    import bpc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            data_en,
    input  logic            pc_en,
    input  logic            xfer_valid,
    input  logic [1:0]      xfer_addr,
    input  logic [1:0]      xfer_size,
    input  logic [DW-1:0]   xfer_data,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] pc_value,
    output logic            data_hit,
    output logic            pc_hit
);

    logic [DW-1:0]   dval, dmask;
    logic [PC_W-1:0] pval, pmask;
    lane_sel_t       lanes;
    logic            data_eq, pc_eq;

    bpc_regfile #(.PW(PC_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .dval   (dval),
        .dmask  (dmask),
        .pval   (pval),
        .pmask  (pmask)
    );

    bpc_lane_align u_align (
        .addr(xfer_addr),
        .size(xfer_size),
        .data(xfer_data),
        .sel (lanes)
    );

    bpc_masked_eq #(.W(DW)) u_data_cmp (
        .a     (lanes.opnd),
        .b     (dval),
        .ignore(dmask | ~lanes.width_m),
        .eq    (data_eq)
    );

    bpc_masked_eq #(.W(PC_W)) u_pc_cmp (
        .a     (pc_value),
        .b     (pval),
        .ignore(pmask),
        .eq    (pc_eq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_hit <= 1'b0;
            pc_hit   <= 1'b0;
        end else begin
            data_hit <= xfer_valid & data_en & lanes.legal & data_eq;
            pc_hit   <= pc_valid & pc_en & pc_eq;
        end
    end

endmodule

// File: rtl/bpc_trigger_chk.sv
module bpc_trigger_chk #(
    parameter int DW   = 32,
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [DW-1:0]   wr_data,
    input logic            data_en,
    input logic            pc_en,
    input logic            xfer_valid,
    input logic [1:0]      xfer_size,
    input logic [DW-1:0]   xfer_data,
    input logic            pc_valid,
    input logic [PC_W-1:0] pc_value,
    input logic            data_hit,
    input logic            pc_hit,
    input logic [DW-1:0]   dval,
    input logic [DW-1:0]   dmask,
    input logic [PC_W-1:0] pval,
    input logic [PC_W-1:0] pmask
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!data_hit && !pc_hit));

    a_r2_dval_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (dval == $past(wr_data)));

    a_r2_pmask_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (pmask == PC_W'($past(wr_data))));

    a_r3_long_match: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && data_en && xfer_size == 2'b00 &&
         ((xfer_data ^ dval) & ~dmask) == '0) |=> data_hit);

    a_r6_rsvd_size: assert property (@(posedge clk) disable iff (rst)
        (xfer_size == 2'b11) |=> !data_hit);

    a_r7_needs_xfer: assert property (@(posedge clk) disable iff (rst)
        !(xfer_valid && data_en) |=> !data_hit);

    a_r8_pc_match: assert property (@(posedge clk) disable iff (rst)
        (pc_valid && pc_en && ((pc_value ^ pval) & ~pmask) == '0) |=> pc_hit);

    a_r9_pc_gate: assert property (@(posedge clk) disable iff (rst)
        !(pc_valid && pc_en) |=> !pc_hit);

    a_r10_all_masked: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && data_en && xfer_size != 2'b11 && dmask == '1) |=> data_hit);

endmodule

bind bpc_trigger bpc_trigger_chk #(.DW(bpc_pkg::DW), .PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .data_en   (data_en),
    .pc_en     (pc_en),
    .xfer_valid(xfer_valid),
    .xfer_size (xfer_size),
    .xfer_data (xfer_data),
    .pc_valid  (pc_valid),
    .pc_value  (pc_value),
    .data_hit  (data_hit),
    .pc_hit    (pc_hit),
    .dval      (dval),
    .dmask     (dmask),
    .pval      (pval),
    .pmask     (pmask)
);

// File: tb/bpc_trigger_test.sv
module bpc_trigger_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        data_en, pc_en;
    logic        xfer_valid;
    logic [1:0]  xfer_addr, xfer_size;
    logic [31:0] xfer_data;
    logic        pc_valid;
    logic [31:0] pc_value;
    logic        data_hit, pc_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bpc_trigger uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .data_en(data_en), .pc_en(pc_en), .xfer_valid(xfer_valid),
        .xfer_addr(xfer_addr), .xfer_size(xfer_size), .xfer_data(xfer_data),
        .pc_valid(pc_valid), .pc_value(pc_value),
        .data_hit(data_hit), .pc_hit(pc_hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one transfer, return the registered hit a cycle later
    task automatic xfer(input logic v, input logic [1:0] sz, input logic [1:0] a,
                        input logic [31:0] d, output logic hit);
        @(negedge clk);
        xfer_valid = v; xfer_size = sz; xfer_addr = a; xfer_data = d;
        @(negedge clk);
        hit = data_hit;
        xfer_valid = 1'b0;
    endtask

    task automatic pc_probe(input logic v, input logic [31:0] pc, output logic hit);
        @(negedge clk);
        pc_valid = v; pc_value = pc;
        @(negedge clk);
        hit = pc_hit;
        pc_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic h;
        check("R1 data_hit in reset", data_hit, 1'b0);
        check("R1 pc_hit in reset", pc_hit, 1'b0);
        @(negedge clk); rst = 1'b0;
        xfer(1'b1, 2'b00, 2'b00, 32'h0, h);
        check("R1 zero data regs match zero", h, 1'b1);
        pc_probe(1'b1, 32'h0, h);
        check("R1 zero PC regs match zero", h, 1'b1);
    endtask

    task automatic t_long();
        logic h;
        write_reg(2'd0, 32'hDEADBEEF);
        write_reg(2'd1, 32'h0);
        xfer(1'b1, 2'b00, 2'b10, 32'hDEADBEEF, h);
        check("R2 R3 long exact hit", h, 1'b1);
        xfer(1'b1, 2'b00, 2'b00, 32'hDEADBEEE, h);
        check("R3 long one bit off miss", h, 1'b0);
        write_reg(2'd1, 32'h0000_0001);
        xfer(1'b1, 2'b00, 2'b00, 32'hDEADBEEE, h);
        check("R3 masked bit ignored", h, 1'b1);
        xfer(1'b1, 2'b00, 2'b00, 32'h5EADBEEF, h);
        check("R3 unmasked msb differs miss", h, 1'b0);
    endtask

    task automatic t_byte();
        logic h;
        write_reg(2'd0, 32'hFFFF_FFA5);
        write_reg(2'd1, 32'h0);
        xfer(1'b1, 2'b01, 2'd0, 32'hA5112233, h); check("R4 byte addr0 hit", h, 1'b1);
        xfer(1'b1, 2'b01, 2'd1, 32'hA5112233, h); check("R4 byte addr1 miss", h, 1'b0);
        xfer(1'b1, 2'b01, 2'd1, 32'h11A52233, h); check("R4 byte addr1 hit", h, 1'b1);
        xfer(1'b1, 2'b01, 2'd2, 32'h1122A533, h); check("R4 byte addr2 hit", h, 1'b1);
        xfer(1'b1, 2'b01, 2'd3, 32'h112233A5, h); check("R4 byte addr3 hit", h, 1'b1);
        xfer(1'b1, 2'b01, 2'd3, 32'hA5112233, h); check("R4 byte addr3 miss", h, 1'b0);
        write_reg(2'd1, 32'h0000_000F);
        xfer(1'b1, 2'b01, 2'd2, 32'h1122A033, h); check("R4 byte low mask", h, 1'b1);
    endtask

    task automatic t_word();
        logic h;
        write_reg(2'd0, 32'h0000BEEF);
        write_reg(2'd1, 32'h0);
        xfer(1'b1, 2'b10, 2'd0, 32'hBEEF1234, h); check("R5 word addr0 hit", h, 1'b1);
        xfer(1'b1, 2'b10, 2'd1, 32'hBEEF1234, h); check("R5 word addr bit0 ignored", h, 1'b1);
        xfer(1'b1, 2'b10, 2'd2, 32'hBEEF1234, h); check("R5 word addr2 miss", h, 1'b0);
        xfer(1'b1, 2'b10, 2'd3, 32'h1234BEEF, h); check("R5 word addr3 hit", h, 1'b1);
    endtask

    task automatic t_size_and_gate();
        logic h;
        write_reg(2'd1, 32'hFFFF_FFFF);
        xfer(1'b1, 2'b00, 2'd1, 32'h0123_4567, h); check("R10 all masked long", h, 1'b1);
        xfer(1'b1, 2'b01, 2'd2, 32'h89AB_CDEF, h); check("R10 all masked byte", h, 1'b1);
        xfer(1'b1, 2'b11, 2'd0, 32'h0123_4567, h); check("R6 reserved size", h, 1'b0);
        xfer(1'b0, 2'b00, 2'd0, 32'h0, h); check("R7 no valid", h, 1'b0);
        data_en = 1'b0;
        xfer(1'b1, 2'b00, 2'd0, 32'h0, h); check("R7 data_en low", h, 1'b0);
        data_en = 1'b1;
        xfer(1'b1, 2'b00, 2'd0, 32'h0, h); check("R7 pulse high", h, 1'b1);
        @(negedge clk);
        check("R7 pulse one cycle", data_hit, 1'b0);
    endtask

    task automatic t_pc();
        logic h;
        write_reg(2'd2, 32'h0040_1000);
        write_reg(2'd3, 32'h0000_000F);
        pc_probe(1'b1, 32'h0040_100C, h); check("R8 masked pc hit", h, 1'b1);
        @(negedge clk);
        check("R8 pc pulse one cycle", pc_hit, 1'b0);
        pc_probe(1'b1, 32'h0040_1010, h); check("R8 pc miss", h, 1'b0);
        pc_probe(1'b0, 32'h0040_1000, h); check("R8 no strobe", h, 1'b0);
        pc_en = 1'b0;
        pc_probe(1'b1, 32'h0040_1000, h); check("R9 pc_en low", h, 1'b0);
        pc_en = 1'b1;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        data_en = 1'b1; pc_en = 1'b1;
        xfer_valid = 1'b0; xfer_addr = '0; xfer_size = '0; xfer_data = '0;
        pc_valid = 1'b0; pc_value = '0;
        repeat (4) @(negedge clk);
        t_reset();
        t_long();
        t_byte();
        t_word();
        t_size_and_gate();
        t_pc();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule